// File: doc/BRIEF.md
# Infrared SIR Frame Assembler

This block turns a stream of payload bytes into a complete asynchronous infrared (SIR) link frame, one byte at a time, for a downstream byte encoder. A frame opens with a programmable run of 0xFF wake-up flags and a 0xC0 opening flag. The payload follows with control-escape stuffing. A 16-bit check sequence comes next, and a 0xC1 closing flag ends the frame.

Payload arrives on a ready/valid stream with a last-byte marker. Output leaves on a valid/ready byte handshake. Each payload byte goes through to the output in the cycle it is accepted, so the block stores no payload. The upstream side is stalled while the block inserts flags, escape bytes or check bytes. The length of the wake-up run comes from a register input. That input is captured when a frame starts, and later changes do not affect the frame in progress.

Top module: `sir_frame_asm`

## Requirements
- R1: A frame starts in the first cycle that in_valid_i is high while the block is idle. The first output bytes are exactly N bytes of 0xFF, where N is the value of xbof_cnt_i captured at that edge. N = 0 is allowed and gives no 0xFF bytes.
- R2: Exactly one 0xC0 byte follows the 0xFF run and comes before any payload byte.
- R3: Every payload byte is sent in arrival order. Each byte is accepted upstream exactly once, and the last one is marked by in_last_i.
- R4: A payload byte equal to 0xC0, 0xC1 or 0x7D is sent as 0x7D followed by the byte XOR 0x20. All other payload byte values are sent unchanged.
- R5: After the last payload byte, the block sends the check sequence, low byte first. The check sequence is the ones-complement of a CRC over the payload, taken LSB first, with reflected polynomial 0x8408 and initial value 0xFFFF. Check bytes follow the same escape rule as R4. The payload "123456789" gives check bytes 0x6E, 0x90.
- R6: Each frame ends with one 0xC1 byte. After that byte, out_valid_o stays low until a new frame starts.
- R7: in_ready_o is low while a 0xFF, 0xC0, 0xC1, escape (0x7D) or check byte is being offered. A payload byte is accepted only in the cycle its final encoded byte is accepted downstream.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o is held on the next cycle.
- R9: While rst_ni is low, out_valid_o and in_ready_o are low, whatever in_valid_i does.
- R10: Changes on xbof_cnt_i after a frame has started have no effect on the length of that frame's 0xFF run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xbof_cnt_i | input | CNT_W | Number of 0xFF wake-up flags, captured at frame start |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_last_i | input | 1 | Marks the last payload byte of the frame |
| in_ready_o | output | 1 | Payload byte accepted when high with in_valid_i |
| out_data_o | output | 8 | Encoded frame byte |
| out_valid_o | output | 1 | Encoded byte valid |
| out_ready_i | input | 1 | Downstream accepts the encoded byte |

## Verification
Directed frames separate the corner cases:
- The standard nine-digit vector pins the CRC bit order and the check byte order.
- A single byte with a zero-length wake-up run shows that an empty run is handled.
- A payload made only of 0xC0, 0xC1 and 0x7D exercises back-to-back escapes.
- A payload found by search, whose check sequence contains a reserved byte, shows that check bytes are stuffed too.
- A frame whose xbof_cnt_i is scrambled after the start shows that the count is captured once.

Random frames add mixed lengths, reserved values and 0xFF in the payload, upstream gaps and a stalling downstream. These expose lost, duplicated or reordered bytes and output that changes while stalled.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int          BYTE_W   = 8;
  localparam int          FCS_W    = 16;
  localparam logic [7:0]  XBOF_B   = 8'hFF;
  localparam logic [7:0]  BOF_B    = 8'hC0;
  localparam logic [7:0]  EOF_B    = 8'hC1;
  localparam logic [7:0]  ESC_B    = 8'h7D;
  localparam logic [7:0]  ESC_X    = 8'h20;
  localparam logic [15:0] CRC_POLY = 16'h8408;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_XBOF, ST_BOF, ST_DATA, ST_DESC, ST_FCS, ST_EOF
  } sir_st_e;
endpackage

// File: rtl/sir_esc.sv
module sir_esc
  import sir_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              special_o,
  output logic [BYTE_W-1:0] flip_o
);
  assign special_o = (byte_i == BOF_B) || (byte_i == EOF_B) || (byte_i == ESC_B);
  assign flip_o    = byte_i ^ ESC_X;
endmodule

// File: rtl/sir_fcs.sv
module sir_fcs #(
  parameter int             DW   = 8,
  parameter int             CW   = 16,
  parameter logic [CW-1:0]  POLY = 16'h8408,
  parameter logic [CW-1:0]  INIT = 16'hFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          en_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] fcs_o
);
  logic [CW-1:0] crc_q, crc_nxt;

  // LSB-first reflected update, one bit per loop step
  always_comb begin
    crc_nxt = crc_q;
    for (int i = 0; i < DW; i++) begin
      crc_nxt = (crc_nxt >> 1) ^ (((crc_nxt[0] ^ data_i[i]) != 1'b0) ? POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else if (en_i)    crc_q <= crc_nxt;
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/sir_frame_asm.sv
module sir_frame_asm
  import sir_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] xbof_cnt_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i
);
  sir_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fidx_q, fidx_d;   // 0: low check byte, 1: high
  logic             eph_q, eph_d;     // escape prefix already sent
  logic [FCS_W-1:0] fcs;
  logic             crc_clr, crc_en;
  logic             in_spec, fcs_spec;
  logic [7:0]       in_flip, fcs_flip, fcs_byte;

  assign fcs_byte = fidx_q ? fcs[15:8] : fcs[7:0];

  sir_esc u_in_esc (.byte_i(in_data_i), .special_o(in_spec),  .flip_o(in_flip));
  sir_esc u_fcs_esc(.byte_i(fcs_byte),  .special_o(fcs_spec), .flip_o(fcs_flip));

  sir_fcs #(
    .DW(BYTE_W), .CW(FCS_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
  ) u_fcs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(crc_clr), .en_i(crc_en),
    .data_i(in_data_i), .fcs_o(fcs)
  );

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    fidx_d      = fidx_q;
    eph_d       = eph_q;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    in_ready_o  = 1'b0;
    crc_clr     = 1'b0;
    crc_en      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid_i) begin
          crc_clr = 1'b1;
          cnt_d   = xbof_cnt_i;
          fidx_d  = 1'b0;
          eph_d   = 1'b0;
          st_d    = (xbof_cnt_i == '0) ? ST_BOF : ST_XBOF;
        end
      end
      ST_XBOF: begin
        out_valid_o = 1'b1;
        out_data_o  = XBOF_B;
        if (out_ready_i) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_d = ST_BOF;
        end
      end
      ST_BOF: begin
        out_valid_o = 1'b1;
        out_data_o  = BOF_B;
        if (out_ready_i) st_d = ST_DATA;
      end
      ST_DATA: begin
        out_valid_o = in_valid_i;
        if (in_spec) begin
          // prefix only; payload byte stays pending upstream
          out_data_o = ESC_B;
          if (in_valid_i && out_ready_i) st_d = ST_DESC;
        end else begin
          out_data_o = in_data_i;
          in_ready_o = out_ready_i;
          if (in_valid_i && out_ready_i) begin
            crc_en = 1'b1;
            if (in_last_i) st_d = ST_FCS;
          end
        end
      end
      ST_DESC: begin
        out_valid_o = in_valid_i;
        out_data_o  = in_flip;
        in_ready_o  = out_ready_i;
        if (in_valid_i && out_ready_i) begin
          crc_en = 1'b1;
          st_d   = in_last_i ? ST_FCS : ST_DATA;
        end
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        if (fcs_spec && !eph_q) begin
          out_data_o = ESC_B;
          if (out_ready_i) eph_d = 1'b1;
        end else begin
          out_data_o = eph_q ? fcs_flip : fcs_byte;
          if (out_ready_i) begin
            eph_d = 1'b0;
            if (fidx_q) st_d = ST_EOF;
            else        fidx_d = 1'b1;
          end
        end
      end
      ST_EOF: begin
        out_valid_o = 1'b1;
        out_data_o  = EOF_B;
        if (out_ready_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      fidx_q <= 1'b0;
      eph_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      fidx_q <= fidx_d;
      eph_q  <= eph_d;
    end
  end
endmodule

// File: rtl/sir_frame_asm_chk.sv
module sir_frame_asm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] in_data_i,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic [7:0] out_data_o,
  input logic       out_valid_o,
  input logic       out_ready_i
);
  logic out_fire;
  assign out_fire = out_valid_o && out_ready_i;

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R7
  in_accept_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |-> out_fire);

  // R4
  esc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !in_ready_o && out_data_o == 8'h7D |=>
      !out_valid_o || out_data_o == 8'hE0 || out_data_o == 8'hE1 || out_data_o == 8'h5D);

  // R6
  eof_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !in_ready_o && out_data_o == 8'hC1 |=> !out_valid_o);

  // R2
  bof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && !in_ready_o && out_data_o == 8'hC0 |=>
      !out_valid_o || (out_data_o != 8'hC0 && out_data_o != 8'hC1));
endmodule

bind sir_frame_asm sir_frame_asm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_data_o(out_data_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i)
);

// File: tb/sir_frame_asm_bench.sv
module sir_frame_asm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 6;

  typedef logic [7:0] bq_t[$];

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] xbof_cnt = '0;
  logic [7:0]       in_data = '0;
  logic             in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0]       out_data;
  logic             out_valid, out_ready = 1'b0;

  int n_chk = 0, n_err = 0;
  int ready_pct = 100;
  bq_t got_q;
  int r7_bad = 0, r8_bad = 0;
  logic hold_pend = 1'b0;
  logic [7:0] hold_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_frame_asm #(.CNT_W(CNT_W)) u_sir_frame_asm (
    .clk_i(clk), .rst_ni(rst_n), .xbof_cnt_i(xbof_cnt), .in_data_i(in_data),
    .in_valid_i(in_valid), .in_last_i(in_last), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready)
  );

  function automatic bit is_spec(input logic [7:0] b);
    return b == 8'hC0 || b == 8'hC1 || b == 8'h7D;
  endfunction

  function automatic logic [15:0] fcs_of(input bq_t pl);
    logic [15:0] c = 16'hFFFF;
    foreach (pl[k]) begin
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ pl[k][i]) c = (c >> 1) ^ 16'h8408;
        else                 c = c >> 1;
      end
    end
    return ~c;
  endfunction

  function automatic void push_esc(ref bq_t q, input logic [7:0] b);
    if (is_spec(b)) begin q.push_back(8'h7D); q.push_back(b ^ 8'h20); end
    else q.push_back(b);
  endfunction

  function automatic bq_t build_exp(input bq_t pl, input int cnt);
    bq_t q;
    logic [15:0] f = fcs_of(pl);
    for (int i = 0; i < cnt; i++) q.push_back(8'hFF);
    q.push_back(8'hC0);
    foreach (pl[k]) push_esc(q, pl[k]);
    push_esc(q, f[7:0]);
    push_esc(q, f[15:8]);
    q.push_back(8'hC1);
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: sampled at negedge, inputs move at posedge+1
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend && !(out_valid && out_data == hold_data)) r8_bad++;
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (out_valid && out_ready) got_q.push_back(out_data);
      if (in_valid && in_ready) begin
        if (!(out_valid && out_ready) ||
            !(out_data == in_data || (is_spec(in_data) && out_data == (in_data ^ 8'h20))))
          r7_bad++;
      end
    end else begin
      hold_pend = 1'b0;
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = ($urandom_range(99) < ready_pct);
    end
  end

  task automatic run_frame(input bq_t pl, input int cnt, input bit scramble, input string req);
    bq_t exp;
    bit  acc;
    int  wait_c;
    exp = build_exp(pl, cnt);
    got_q.delete();
    r7_bad = 0;
    r8_bad = 0;
    @(posedge clk); #1;
    xbof_cnt = CNT_W'(cnt);
    foreach (pl[k]) begin
      int gap = $urandom_range(2);
      for (int g = 0; g < gap; g++) begin @(posedge clk); #1; end
      in_valid = 1'b1;
      in_data  = pl[k];
      in_last  = (k == pl.size() - 1);
      do begin
        @(negedge clk);
        acc = in_ready;
        @(posedge clk); #1;
        if (scramble) xbof_cnt = CNT_W'($urandom);
      end while (!acc);
      in_valid = 1'b0;
    end
    in_last = 1'b0;
    wait_c = 0;
    while (got_q.size() < exp.size() && wait_c < 4000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (4) @(negedge clk);
    begin
      int bad = -1;
      if (got_q.size() == exp.size()) begin
        foreach (exp[i]) if (bad < 0 && got_q[i] !== exp[i]) bad = i;
        if (bad < 0) check(1'b1, req, "frame", 0, 0);
        else check(1'b0, req, $sformatf("frame byte %0d", bad), 32'(got_q[bad]), 32'(exp[bad]));
      end else begin
        check(1'b0, req, "frame length", got_q.size(), exp.size());
      end
    end
    check(r7_bad == 0, "R7", "bad payload accepts", r7_bad, 0);
    check(r8_bad == 0, "R8", "unstable stalled bytes", r8_bad, 0);
  endtask

  initial begin
    int found;
    bq_t pl;
    void'($urandom(32'h5EED));

    // R9: reset holds outputs low even with input offered
    in_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && !in_ready, "R9", "outputs in reset", {out_valid, in_ready}, 0);
    in_valid = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !in_ready, "R9", "idle after reset", {out_valid, in_ready}, 0);

    // R5: standard vector, check bytes 6E 90 at positions 10, 11
    pl = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    run_frame(pl, 0, 1'b0, "R5");
    check(got_q.size() > 11 && got_q[10] == 8'h6E && got_q[11] == 8'h90, "R5",
          "check bytes", {got_q.size() > 11 ? got_q[11] : 8'h0, got_q.size() > 10 ? got_q[10] : 8'h0}, 16'h906E);
    check(got_q.size() > 0 && got_q[0] == 8'hC0, "R1", "zero wake-up run first byte",
          got_q.size() > 0 ? got_q[0] : 8'h0, 8'hC0);

    // R1: zero count, single byte
    pl = '{8'h55};
    run_frame(pl, 0, 1'b0, "R1");

    // R4: only reserved values
    pl = '{8'hC0, 8'hC1, 8'h7D, 8'h7D, 8'hC0};
    run_frame(pl, 3, 1'b0, "R4");

    // R5: check sequence containing a reserved byte
    found = -1;
    for (int v = 0; v < 256 && found < 0; v++) begin
      bq_t t;
      logic [15:0] f;
      t.push_back(8'(v));
      t.push_back(8'h5A);
      f = fcs_of(t);
      if (is_spec(f[7:0]) || is_spec(f[15:8])) found = v;
    end
    if (found >= 0) begin
      pl = '{8'(found), 8'h5A};
      run_frame(pl, 2, 1'b0, "R5");
    end

    // R10: count scrambled after frame start
    pl = '{8'h11, 8'hC1, 8'h22, 8'hFF};
    run_frame(pl, 5, 1'b1, "R10");

    // R8: slow downstream
    ready_pct = 30;
    pl = '{8'hFF, 8'h7D, 8'h00, 8'hA5, 8'hC0};
    run_frame(pl, 4, 1'b0, "R8");

    // random frames: R3 ordering with mixed content
    for (int f = 0; f < 30; f++) begin
      bq_t rp;
      int len = $urandom_range(12, 1);
      ready_pct = $urandom_range(100, 40);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(3) == 0) begin
          case ($urandom_range(3))
            0: rp.push_back(8'hC0);
            1: rp.push_back(8'hC1);
            2: rp.push_back(8'h7D);
            default: rp.push_back(8'hFF);
          endcase
        end else rp.push_back(8'($urandom));
      end
      run_frame(rp, $urandom_range(12), 1'b0, "R3");
    end

    // R6: idle after the last frame
    repeat (3) @(negedge clk);
    check(!out_valid, "R6", "idle after frame", out_valid, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule